// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog timer programmed through one 8-bit configuration byte. The two low bits choose a time base. A 16 Hz reference tick is divided by 1, 4, 16 or 64, which gives steps of 1/16 s, 1/4 s, 1 s or 4 s. A five-bit multiplier sets how many steps must pass before the watchdog expires. The top bit steers the expiry to one of two outputs. One is a reset pulse of fixed width. The other is an interrupt level that stays high until software acknowledges it.

Software keeps the system alive by writing the configuration byte again before the count runs out. Every write reloads the count and restarts the time base. A multiplier of zero keeps the watchdog idle. When the count expires, the block raises a status flag that software can only read. Reading it returns the flag to zero and also drops the interrupt. The reset input is asserted asynchronously and released through a two-stage synchronizer inside the block.

Top module: `wdt_steer`

## Requirements
- R1: After reset the configuration byte is zero, and flag_o, irq_o and rst_pulse_o are all low.
- R2: Configuration bits 1:0 select the step length in reference ticks: 00 is 1 tick, 01 is 4 ticks, 10 is 16 ticks and 11 is 64 ticks.
- R3: Configuration bits 6:2 hold the multiplier M. The watchdog expires on the reference tick that completes M steps after the last write. Its outputs change on the clock edge that samples that tick.
- R4: While the multiplier is zero, the watchdog never expires and no output rises.
- R5: Every write to the configuration byte reloads the count and clears the partial step. If a write coincides with the expiring tick, the write wins and no expiry happens.
- R6: flag_o rises at expiry and holds until a cycle with flag_rd_i high, which clears it on the next edge. An expiry in the same cycle as a read leaves the flag set.
- R7: With bit 7 set to 1, an expiry drives rst_pulse_o high for exactly PULSE_W cycles and leaves irq_o unchanged.
- R8: With bit 7 set to 0, an expiry raises irq_o, which stays high until a flag read clears it. No reset pulse is produced.
- R9: After expiry the count stays stopped, and no further expiry happens until the configuration is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse at 16 Hz, the time reference |
| cfg_we_i | input | 1 | Write strobe for the configuration byte |
| cfg_wdata_i | input | 8 | Configuration byte: [7] steer, [6:2] multiplier, [1:0] step select |
| flag_rd_i | input | 1 | Read strobe for the status flag; clears it |
| flag_o | output | 1 | Watchdog expired flag (read-only) |
| irq_o | output | 1 | Interrupt level, used when steer is 0 |
| rst_pulse_o | output | 1 | Reset pulse of PULSE_W cycles, used when steer is 1 |

## Verification
The hardest situation to bring about is a configuration write that lands in the very cycle the expiring reference tick is sampled, since a write normally moves the expiry away. The stimulus watches the bench's own model of the count and the tick schedule. It raises the write strobe only when the remaining count is one and a tick is present, so the two collide on the same edge. The matching collision between a flag read and an expiry is reached by holding the read strobe high across the whole expiry window, so the flag is expected to show for a single cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MULT_W  = 5;
  localparam int RES_W   = 2;
  localparam int CFG_W   = 1 + MULT_W + RES_W;

  typedef enum logic [RES_W-1:0] {
    RES_SIXTEENTH = 2'd0,
    RES_QUARTER   = 2'd1,
    RES_ONE       = 2'd2,
    RES_FOUR      = 2'd3
  } res_e;

  typedef struct packed {
    logic              steer_rst;
    logic [MULT_W-1:0] mult;
    res_e              res;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int RES_W     = 2,
  parameter int RATIO_LOG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] res_i,
  output logic             step_o
);
  localparam int PRE_W = RATIO_LOG * ((1 << RES_W) - 1);

  logic [PRE_W-1:0] cnt_q, cnt_d, lim;
  logic             at_lim;

  always_comb begin
    for (int k = 0; k < PRE_W; k++) begin
      lim[k] = (k < RATIO_LOG * int'(res_i));
    end
  end

  assign at_lim = (cnt_q == lim);
  assign step_o = tick_i && at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = at_lim ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int MULT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MULT_W-1:0] load_val_i,
  input  logic              step_i,
  output logic              expire_o
);
  logic [MULT_W-1:0] cnt_q, cnt_d;
  logic              live;

  assign live     = (cnt_q != '0);
  assign expire_o = step_i && !load_i && (cnt_q == MULT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (step_i && live) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_outctl.sv
module wdt_outctl #(
  parameter int PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic steer_rst_i,
  input  logic flag_rd_i,
  output logic flag_o,
  output logic irq_o,
  output logic rst_pulse_o
);
  localparam int PW_CW = $clog2(PULSE_W + 1);

  logic             flag_q, flag_d;
  logic             irq_q, irq_d;
  logic [PW_CW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    flag_d = flag_q;
    if (expire_i)       flag_d = 1'b1;
    else if (flag_rd_i) flag_d = 1'b0;

    irq_d = irq_q;
    if (expire_i && !steer_rst_i) irq_d = 1'b1;
    else if (flag_rd_i)           irq_d = 1'b0;

    pcnt_d = pcnt_q;
    if (expire_i && steer_rst_i) pcnt_d = PW_CW'(PULSE_W);
    else if (pcnt_q != '0)       pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign flag_o      = flag_q;
  assign irq_o       = irq_q;
  assign rst_pulse_o = (pcnt_q != '0);
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
#(
  parameter int PULSE_W   = 4,
  parameter int RATIO_LOG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             flag_rd_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             rst_pulse_o
);
  logic     rst_n;
  wdt_cfg_t cfg_q, cfg_d;
  logic     step, expire;

  wdt_rst_sync #(.STAGES(2)) u_rsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we_i) cfg_d = wdt_cfg_t'(cfg_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  wdt_prescale #(.RES_W(RES_W), .RATIO_LOG(RATIO_LOG)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (tick_i),
    .clr_i  (cfg_we_i),
    .res_i  (cfg_q.res),
    .step_o (step)
  );

  wdt_downcnt #(.MULT_W(MULT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (cfg_we_i),
    .load_val_i (cfg_wdata_i[RES_W +: MULT_W]),
    .step_i     (step),
    .expire_o   (expire)
  );

  wdt_outctl #(.PULSE_W(PULSE_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .expire_i    (expire),
    .steer_rst_i (cfg_q.steer_rst),
    .flag_rd_i   (flag_rd_i),
    .flag_o      (flag_o),
    .irq_o       (irq_o),
    .rst_pulse_o (rst_pulse_o)
  );
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
  parameter int PULSE_W = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flag_rd_i,
  input logic       flag_o,
  input logic       irq_o,
  input logic       rst_pulse_o,
  input logic       expire,
  input logic [7:0] cfg_q
);
  localparam int CW = $clog2(PULSE_W + 1);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  win_q <= '0;
    else if (expire && cfg_q[7])  win_q <= CW'(PULSE_W);
    else if (win_q != '0)         win_q <= win_q - 1'b1;
  end

  p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o == (win_q != '0));

  p_pulse_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pulse_o) |-> flag_o);

  p_irq_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_rd_i) |=> irq_o);

  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_rd_i) |=> flag_o);

  p_zero_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[6:2] == 5'd0 && !flag_o) |=> !flag_o);
endmodule

bind wdt_steer wdt_steer_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flag_rd_i   (flag_rd_i),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .rst_pulse_o (rst_pulse_o),
  .expire      (expire),
  .cfg_q       (cfg_q)
);

// File: tb/wdt_steer_test.sv
module wdt_steer_test;
  localparam int PW   = 4;
  localparam int TGAP = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i = 1'b0;
  logic       cfg_we_i;
  logic [7:0] cfg_wdata_i;
  logic       flag_rd_i;
  logic       flag_o, irq_o, rst_pulse_o;

  logic       tick_en;
  int         tg = 0;
  int         checks = 0, errors = 0, cyc = 0, nrise = 0;
  logic       prev_flag = 1'b0;
  string      cur_req = "R1";

  // behavioural model state
  int mcfg = 0, mpre = 0, mcnt = 0, mpul = 0;
  bit mflag = 0, mirq = 0;

  wdt_steer #(.PULSE_W(PW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .flag_rd_i(flag_rd_i),
    .flag_o(flag_o), .irq_o(irq_o), .rst_pulse_o(rst_pulse_o)
  );

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (!tick_en) begin
      tick_i <= 1'b0; tg <= 0;
    end else begin
      tick_i <= (tg == TGAP - 1);
      tg     <= (tg == TGAP - 1) ? 0 : tg + 1;
    end
  end

  function automatic int lim_of(int c);
    return (1 << (2 * (c & 3))) - 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcfg = 0; mpre = 0; mcnt = 0; mpul = 0; mflag = 0; mirq = 0;
    end else begin
      bit ex;
      ex = 0;
      if (cfg_we_i) begin
        mcfg = cfg_wdata_i; mpre = 0; mcnt = (cfg_wdata_i >> 2) & 31;
      end else if (tick_i) begin
        if (mpre == lim_of(mcfg)) begin
          mpre = 0;
          if (mcnt > 0) begin
            mcnt = mcnt - 1;
            if (mcnt == 0) ex = 1;
          end
        end else mpre = mpre + 1;
      end
      if (mpul > 0) mpul = mpul - 1;
      if (ex && mcfg[7]) mpul = PW;
      if (ex) mflag = 1; else if (flag_rd_i) mflag = 0;
      if (ex && !mcfg[7]) mirq = 1; else if (flag_rd_i) mirq = 0;
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired in %s: got 0 expected 1", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks = checks + 1;
      if (flag_o !== mflag || irq_o !== mirq || rst_pulse_o !== (mpul > 0)) begin
        errors = errors + 1;
        $display("FAIL %s cyc %0d: flag/irq/rst got %b%b%b expected %b%b%b", cur_req, cyc,
                 flag_o, irq_o, rst_pulse_o, mflag, mirq, (mpul > 0));
      end
      if (flag_o && !prev_flag) nrise = nrise + 1;
      prev_flag = flag_o;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk_i); flag_rd_i = 1'b1;
    @(negedge clk_i); flag_rd_i = 1'b0;
  endtask

  // byte layout: [7] steer (1 reset, 0 irq), [6:2] multiplier, [1:0] step select
  function automatic logic [7:0] mk(input bit st, input int m, input int r);
    return {st, 5'(m), 2'(r)};
  endfunction

  initial begin
    int base;
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = '0; flag_rd_i = 1'b0; tick_en = 1'b0;
    idle(3);
    chk("R1 flag at reset", flag_o, 0);
    chk("R1 irq at reset", irq_o, 0);
    chk("R1 rst pulse at reset", rst_pulse_o, 0);
    rst_ni = 1'b1;
    idle(4);
    tick_en = 1'b1;
    cur_req = "R1 R4 idle after reset";
    idle(60);
    chk("R4 no expiry with reset config", nrise, 0);

    cur_req = "R3 R8 R2 M=3 step 1/16";
    wr(mk(0, 3, 0));
    idle(20);
    chk("R8 irq held", irq_o, 1);
    chk("R6 flag held", flag_o, 1);
    cur_req = "R6 read clears";
    rd();
    idle(2);
    chk("R6 flag cleared", flag_o, 0);
    chk("R8 irq cleared", irq_o, 0);

    cur_req = "R9 stopped after expiry";
    base = nrise;
    idle(60);
    chk("R9 no second expiry", nrise, base);

    cur_req = "R7 R2 M=2 step 1/4 reset steer";
    wr(mk(1, 2, 1));
    idle(40);
    chk("R7 irq stays low", irq_o, 0);
    rd();

    cur_req = "R2 M=1 step 1s";
    wr(mk(0, 1, 2));
    idle(60);
    rd();
    cur_req = "R2 M=1 step 4s";
    wr(mk(1, 1, 3));
    idle(210);
    rd();

    cur_req = "R5 kicks hold off expiry";
    base = nrise;
    for (int k = 0; k < 8; k++) begin
      wr(mk(0, 2, 1));
      idle(15);
    end
    chk("R5 no expiry while kicked", nrise, base);

    cur_req = "R4 zero multiplier during count";
    wr(mk(0, 3, 0));
    idle(4);
    wr(mk(0, 0, 0));
    idle(60);
    chk("R4 zero multiplier never expires", nrise, base);

    cur_req = "R5 write on expiring tick";
    wr(mk(0, 2, 0));
    for (int g = 0; g < 200; g++) begin
      @(negedge clk_i); #1;
      if (tick_i && mcnt == 1) break;
    end
    cfg_we_i = 1'b1; cfg_wdata_i = mk(0, 2, 0);
    @(negedge clk_i); cfg_we_i = 1'b0;
    chk("R5 write beats expiry", flag_o, 0);
    idle(20);

    cur_req = "R6 read held across expiry";
    rd();
    wr(mk(0, 1, 0));
    flag_rd_i = 1'b1;
    base = nrise;
    idle(12);
    flag_rd_i = 1'b0;
    chk("R6 expiry beats read", nrise, base + 1);
    idle(2);
    chk("R6 flag gone after held read", flag_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule